// File: doc/BRIEF.md
# Multiply-Accumulate Bus Peripheral

This block is a register-mapped arithmetic unit that sits on a simple processor bus. Software loads a first operand, then a second operand. The block forms a 32-bit product from two 16-bit operands. It either stores that product as the result or adds it into a 32-bit accumulator held in the result registers. Each operation can treat its operands as unsigned or as two's complement.

The operation is chosen by which of four word locations receives the first operand. Those four locations are aliases of one operand register. Writing the second operand launches the operation. The result appears in a low word, a high word and a read-only extension word two cycles later. The first operand stays in place, so a sequence such as a polynomial evaluation can write it once and then launch many operations by writing only new second operands. Because the accumulator words can be written, software can preload a starting sum before a run of accumulate operations.

Top module: `mac_periph`

## Requirements
- R1: A write at word address 0, 1, 2 or 3 loads the first operand and selects the mode. The mode is the low two address bits: 0 is unsigned multiply, 1 is signed multiply, 2 is unsigned accumulate and 3 is signed accumulate (bit 0 means signed, bit 1 means accumulate). A read at any of the four addresses returns the first operand.
- R2: A write at word address 4 stores the second operand, which reads back at address 4, and starts an operation in the mode last selected.
- R3: The result low word reads at address 5 and the high word at address 6. Both hold the new result from the second cycle after the cycle of the starting write.
- R4: In unsigned accumulate mode, {high,low} becomes the 32-bit sum of the old {high,low} and the product. The extension word (address 7) becomes the carry out of that addition, 0 or 1.
- R5: In both signed modes, the extension word becomes 0x0000 or 0xFFFF, copying bit 15 of the new high word.
- R6: Writes to address 7 are ignored, and the extension word keeps its value.
- R7: Writes at addresses 5 and 6 load the low and high result words, so an accumulation can start from a preloaded value. A result arriving in the same cycle takes precedence over such a write.
- R8: When the byte strobe is set, a write stores bits 7:0 of the write data with the upper byte cleared.
- R9: The first operand is kept, so successive writes at address 4 each start a new operation with that same first operand.
- R10: Unsigned multiply sets the extension word to 0. Both multiply modes replace {high,low} with the product and do not add to it.
- R11: A read of a result word in the cycle right after the starting write returns the previous result.
- R12: After reset, every register reads 0.
- R13: Read data is 0 in any cycle in which the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Word address of the access (byte offset divided by two) |
| bus_wdata | input | 16 | Write data |
| bus_byte | input | 1 | Byte write: use bits 7:0 and zero-extend them |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, combinational from the addressed register |

## Verification
The in-design assertions check the following on every cycle:
- The extension word only ever holds 0, 1 or all ones.
- After a signed result it copies the top bit of the high word.
- After an unsigned multiply it is zero.
- The result words and the first operand do not change without a write or a result.
- A start is always followed one cycle later by an accumulation step.

The bench scenarios show the rest: the actual product and sum values, the carry of an accumulation that wraps, preloading, operand reuse, byte zero-extension, the write-ignored extension word, and the old value seen in the cycle right after a start. A behavioural model compares the read data on every clock during directed sequences and a long random stream of bus traffic.

// File: rtl/mac_pkg.sv
package mac_pkg;

   // bit 0: operands are two's complement, bit 1: add into the accumulator
   typedef enum logic [1:0] {
      MODE_UMPY = 2'd0,
      MODE_SMPY = 2'd1,
      MODE_UMAC = 2'd2,
      MODE_SMAC = 2'd3
   } mac_mode_t;

   // word map of the register window
   localparam logic [2:0] WA_OPB   = 3'd4;
   localparam logic [2:0] WA_RLO   = 3'd5;
   localparam logic [2:0] WA_RHI   = 3'd6;
   localparam logic [2:0] WA_REXT  = 3'd7;

   function automatic logic mode_signed(input mac_mode_t m);
      return m[0];
   endfunction

   function automatic logic mode_accum(input mac_mode_t m);
      return m[1];
   endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult
   import mac_pkg::*;
#(
   parameter int DW = 16
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [DW-1:0]   opa,
   input  logic [DW-1:0]   opb,
   input  mac_mode_t       mode,
   output logic            prod_vld,
   output logic [2*DW-1:0] prod,
   output mac_mode_t       prod_mode
);
   localparam int PW = 2 * DW;
   localparam int XW = DW + 1;

   logic          sgn;
   logic [XW-1:0] xa, xb;
   logic [2*XW-1:0] full;

   assign sgn = mode_signed(mode);
   // one extra top bit: sign copy in signed mode, zero otherwise;
   // the low PW bits of the widened product are correct in both modes
   assign xa   = {sgn & opa[DW-1], opa};
   assign xb   = {sgn & opb[DW-1], opb};
   assign full = $signed(xa) * $signed(xb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_vld  <= 1'b0;
         prod      <= '0;
         prod_mode <= MODE_UMPY;
      end else begin
         prod_vld <= start;
         if (start) begin
            prod      <= full[PW-1:0];
            prod_mode <= mode;
         end
      end
   end

endmodule

// File: rtl/mac_accum.sv
module mac_accum
   import mac_pkg::*;
#(
   parameter int DW = 16
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prod_vld,
   input  logic [2*DW-1:0] prod,
   input  mac_mode_t       prod_mode,
   input  logic            lo_we,
   input  logic            hi_we,
   input  logic [DW-1:0]   wval,
   output logic [DW-1:0]   res_lo,
   output logic [DW-1:0]   res_hi,
   output logic [DW-1:0]   res_ext
);
   localparam int PW = 2 * DW;

   logic [PW-1:0] base;
   logic [PW:0]   sum;
   logic [DW-1:0] ext_nxt;

   assign base = mode_accum(prod_mode) ? {res_hi, res_lo} : '0;
   assign sum  = {1'b0, base} + {1'b0, prod};

   always_comb begin
      if (mode_signed(prod_mode))
         ext_nxt = {DW{sum[PW-1]}};
      else if (mode_accum(prod_mode))
         ext_nxt = DW'(sum[PW]);
      else
         ext_nxt = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_lo  <= '0;
         res_hi  <= '0;
         res_ext <= '0;
      end else if (prod_vld) begin
         res_lo  <= sum[DW-1:0];
         res_hi  <= sum[PW-1:DW];
         res_ext <= ext_nxt;
      end else begin
         if (lo_we) res_lo <= wval;
         if (hi_we) res_hi <= wval;
      end
   end

   AST_EXT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (res_ext == '0) || (res_ext == DW'(1)) || (res_ext == '1)); // R4

   AST_SIGNED_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prod_vld && prod_mode[0]) |-> (res_ext == {DW{res_hi[DW-1]}})); // R5

   AST_UMPY_EXT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prod_vld && prod_mode == MODE_UMPY) |-> (res_ext == '0)); // R10

   AST_UMAC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prod_vld && prod_mode == MODE_UMAC) |-> (res_ext <= DW'(1))); // R4

   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!prod_vld && !lo_we && !hi_we) |=> ($stable(res_lo) && $stable(res_hi) && $stable(res_ext))); // R11

   AST_EXT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !prod_vld |=> $stable(res_ext)); // R6

endmodule

// File: rtl/mac_periph.sv
module mac_periph
   import mac_pkg::*;
#(
   parameter int DW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_byte,
   input  logic          bus_wr,
   input  logic          bus_rd,
   output logic [DW-1:0] bus_rdata
);
   localparam int PW = 2 * DW;

   generate
      if (DW < 8) begin : g_bad_width
         $error("mac_periph: DW must be at least 8 for byte writes");
      end
   endgenerate

   logic [DW-1:0] wval;
   logic          opa_we, start, lo_we, hi_we;
   logic [DW-1:0] opa_q, opb_q;
   mac_mode_t     mode_q;

   logic            prod_vld;
   logic [PW-1:0]   prod;
   mac_mode_t       prod_mode;
   logic [DW-1:0]   res_lo, res_hi, res_ext;

   assign wval   = bus_byte ? DW'(bus_wdata[7:0]) : bus_wdata;
   assign opa_we = bus_wr && !bus_addr[2];
   assign start  = bus_wr && (bus_addr == WA_OPB);
   assign lo_we  = bus_wr && (bus_addr == WA_RLO);
   assign hi_we  = bus_wr && (bus_addr == WA_RHI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opa_q  <= '0;
         opb_q  <= '0;
         mode_q <= MODE_UMPY;
      end else begin
         if (opa_we) begin
            opa_q  <= wval;
            mode_q <= mac_mode_t'(bus_addr[1:0]);
         end
         if (start) opb_q <= wval;
      end
   end

   mac_mult #(.DW(DW)) u_mult (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .opa       (opa_q),
      .opb       (wval),
      .mode      (mode_q),
      .prod_vld  (prod_vld),
      .prod      (prod),
      .prod_mode (prod_mode)
   );

   mac_accum #(.DW(DW)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .prod_vld  (prod_vld),
      .prod      (prod),
      .prod_mode (prod_mode),
      .lo_we     (lo_we),
      .hi_we     (hi_we),
      .wval      (wval),
      .res_lo    (res_lo),
      .res_hi    (res_hi),
      .res_ext   (res_ext)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (bus_addr)
            WA_OPB:  bus_rdata = opb_q;
            WA_RLO:  bus_rdata = res_lo;
            WA_RHI:  bus_rdata = res_hi;
            WA_REXT: bus_rdata = res_ext;
            default: bus_rdata = opa_q;
         endcase
      end
   end

   AST_OPA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !opa_we |=> ($stable(opa_q) && $stable(mode_q))); // R9

   AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> prod_vld); // R3

   AST_OPB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (opb_q == $past(wval))); // R2

endmodule

// File: tb/sim_mac_periph.sv
module sim_mac_periph;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_byte = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_rdata;

   always #10 clk = ~clk;   // 50 MHz

   mac_periph u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_byte(bus_byte), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // behavioural reference state
   logic [15:0] m_opa = 0, m_opb = 0, m_lo = 0, m_hi = 0, m_ext = 0;
   logic [1:0]  m_mode = 0;
   int          cyc = 0;
   logic [31:0] q_prod[$];
   logic [1:0]  q_mode[$];
   int          q_due[$];
   logic [15:0] last_rd;

   function automatic string tag_of(input logic [2:0] a);
      if (a < 3'd4) return "R1";
      if (a == 3'd4) return "R2";
      if (a == 3'd7) return "R5";
      return "R3";
   endfunction

   function automatic logic [15:0] model_read(input logic rd, input logic [2:0] a);
      if (!rd) return 16'h0;
      case (a)
         3'd4: return m_opb;
         3'd5: return m_lo;
         3'd6: return m_hi;
         3'd7: return m_ext;
         default: return m_opa;
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic model_edge(input logic wr, input logic [2:0] a,
                             input logic [15:0] d, input logic byt);
      logic [15:0] v;
      bit commit;
      longint sa, sb, p, base, s;
      logic [1:0] md;
      cyc++;
      commit = 0;
      if (q_due.size() > 0 && q_due[0] == cyc) begin
         commit = 1;
         md = q_mode.pop_front();
         void'(q_due.pop_front());
         p = longint'(q_prod.pop_front());
         base = md[1] ? longint'({m_hi, m_lo}) : 0;
         s = base + p;
         m_lo = s[15:0];
         m_hi = s[31:16];
         if (md[0]) m_ext = s[31] ? 16'hFFFF : 16'h0000;
         else if (md[1]) m_ext = {15'h0, s[32]};
         else m_ext = 16'h0;
      end
      v = byt ? {8'h00, d[7:0]} : d;
      if (wr) begin
         if (a < 3'd4) begin
            m_opa = v;
            m_mode = a[1:0];
         end else if (a == 3'd4) begin
            sa = m_mode[0] ? longint'($signed(m_opa)) : longint'(m_opa);
            sb = m_mode[0] ? longint'($signed(v)) : longint'(v);
            p = sa * sb;
            q_prod.push_back(p[31:0]);
            q_mode.push_back(m_mode);
            q_due.push_back(cyc + 1);
            m_opb = v;
         end else if (a == 3'd5) begin
            if (!commit) m_lo = v;
         end else if (a == 3'd6) begin
            if (!commit) m_hi = v;
         end
      end
   endtask

   // one bus cycle: drive, compare against the model before the edge, advance model
   task automatic step(input logic wr, input logic rd, input logic [2:0] a,
                       input logic [15:0] d, input logic byt);
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; bus_byte = byt;
      #1;
      last_rd = bus_rdata;
      check(rd ? tag_of(a) : "R13", bus_rdata, model_read(rd, a));
      @(posedge clk);
      model_edge(wr, a, d, byt);
   endtask

   task automatic wr16(input logic [2:0] a, input logic [15:0] d);
      step(1'b1, 1'b0, a, d, 1'b0);
   endtask

   task automatic rd_exp(input string tag, input logic [2:0] a, input logic [15:0] exp);
      step(1'b0, 1'b1, a, 16'h0, 1'b0);
      check(tag, last_rd, exp);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R12: everything reads zero after reset
      for (int a = 0; a < 8; a++) rd_exp("R12", 3'(a), 16'h0000);

      // R10 unsigned multiply, R11 old value in the cycle after start
      wr16(3'd0, 16'h1234);
      wr16(3'd4, 16'h0010);
      rd_exp("R11", 3'd5, 16'h0000);
      rd_exp("R3", 3'd5, 16'h2340);
      rd_exp("R3", 3'd6, 16'h0001);
      rd_exp("R10", 3'd7, 16'h0000);
      rd_exp("R2", 3'd4, 16'h0010);

      // R1 aliases and signed multiply
      wr16(3'd1, 16'hFFFE);
      rd_exp("R1", 3'd0, 16'hFFFE);
      rd_exp("R1", 3'd2, 16'hFFFE);
      rd_exp("R1", 3'd3, 16'hFFFE);
      wr16(3'd4, 16'h0003);
      step(1'b0, 1'b0, 3'd0, 16'h0, 1'b0);
      rd_exp("R5", 3'd5, 16'hFFFA);
      rd_exp("R5", 3'd6, 16'hFFFF);
      rd_exp("R5", 3'd7, 16'hFFFF);

      // R7 preload, R4 carry out, R9 operand reuse
      wr16(3'd5, 16'hFFFF);
      wr16(3'd6, 16'hFFFF);
      rd_exp("R7", 3'd5, 16'hFFFF);
      wr16(3'd2, 16'h0001);
      wr16(3'd4, 16'h0001);
      step(1'b0, 1'b0, 3'd0, 16'h0, 1'b0);
      rd_exp("R4", 3'd5, 16'h0000);
      rd_exp("R4", 3'd6, 16'h0000);
      rd_exp("R4", 3'd7, 16'h0001);
      wr16(3'd4, 16'h0002);
      step(1'b0, 1'b0, 3'd0, 16'h0, 1'b0);
      rd_exp("R9", 3'd5, 16'h0002);
      rd_exp("R9", 3'd7, 16'h0000);

      // signed accumulate: 5 + (-1 * 8) = -3
      wr16(3'd5, 16'h0005);
      wr16(3'd6, 16'h0000);
      wr16(3'd3, 16'hFFFF);
      wr16(3'd4, 16'h0008);
      step(1'b0, 1'b0, 3'd0, 16'h0, 1'b0);
      rd_exp("R5", 3'd5, 16'hFFFD);
      rd_exp("R5", 3'd6, 16'hFFFF);

      // R6 extension write ignored
      wr16(3'd7, 16'h1234);
      rd_exp("R6", 3'd7, 16'hFFFF);

      // R10 plain multiply overwrites the accumulator
      wr16(3'd0, 16'h0002);
      wr16(3'd4, 16'h0003);
      step(1'b0, 1'b0, 3'd0, 16'h0, 1'b0);
      rd_exp("R10", 3'd5, 16'h0006);
      rd_exp("R10", 3'd6, 16'h0000);
      rd_exp("R10", 3'd7, 16'h0000);

      // R8 byte writes zero-extend
      step(1'b1, 1'b0, 3'd0, 16'hABCD, 1'b1);
      rd_exp("R8", 3'd0, 16'h00CD);
      step(1'b1, 1'b0, 3'd4, 16'h1202, 1'b1);
      rd_exp("R8", 3'd4, 16'h0002);
      rd_exp("R8", 3'd5, 16'h019A);

      // R13 idle read strobe
      step(1'b0, 1'b0, 3'd5, 16'h0, 1'b0);
      check("R13", last_rd, 16'h0000);

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              3'($urandom_range(0, 7)), 16'($urandom), 1'($urandom_range(0, 3) == 0));
      end
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 3'd0, 16'h0, 1'b0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule